// File: doc/BRIEF.md
# Sinc Decimation Filter with Settling Gate

This block decimates a 1-bit sigma-delta stream into signed 16-bit results. Each strobe on `in_valid` delivers one sample. A one counts as +1 and a zero counts as -1. The samples pass through a cascade of integrators, and the integrator output is then differenced at the decimation rate. The block supports Sinc orders 1 to 5 and a FastSinc mode. FastSinc is a second-order response over a window of twice the oversampling ratio, and it still emits one result every oversampling-ratio samples.

Conversion runs continuously while `en` is high. The block counts the samples taken since it was enabled and keeps `out_valid` low until the filter window is fully populated. The length of that settling period depends on the order, and FastSinc has its own count. After the first result, results follow at a fixed cadence. Clearing `en` discards all filter state, so the next enable starts settling again from zero. An oversampling field of zero selects bypass, which turns every sample straight into a ±1 result.

Top module: `sinc_decim`

## Requirements
- R1: After reset, and on the cycle after any cycle with `en` low, `out_valid` is 0 and `out_data` is 0.
- R2: `order_sel` picks the response. A value of 1 to 5 selects a Sinc filter of that order, 0 selects FastSinc, and 6 or 7 behave as order 5. The oversampling ratio F is `osr_m1`+1.
- R3: Input bit 1 counts as +1 and bit 0 counts as -1, with zero history before enable. Each Sinc result equals the input convolved with a length-F boxcar taken N times, evaluated at the emitting sample.
- R4: In Sinc mode, the first result is emitted on sample number F*N+N+1 after enable.
- R5: In FastSinc mode, the first result is emitted on sample 4F+3. Its value is the input convolved twice with a length-2F boxcar.
- R6: After the first result, a result is emitted on every F-th sample.
- R7: A result above 32767 is clamped to 32767, and a result below -32768 is clamped to -32768.
- R8: With `osr_m1`=0 (bypass), every sample produces a result of +1 or -1 with no settling delay.
- R9: Dropping `en` mid-stream clears all filter state. After re-enable, the settling count starts again from the first new sample.
- R10: `out_valid` is a one-cycle pulse. It is high in the cycle after the clock edge that took the emitting sample, and it is never raised without a sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Channel enable; low clears filter state |
| in_valid | input | 1 | Sample strobe |
| in_bit | input | 1 | Serial sample, 1 = +1, 0 = -1 |
| osr_m1 | input | 5 | Oversampling ratio minus one; 0 selects bypass |
| order_sel | input | 3 | 0 = FastSinc, 1..5 = Sinc order |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 16 | Signed saturated result |

## Verification
A result is due exactly one clock after the edge that captures the emitting sample. The emitting sample is number N*F+N+1, or 4F+3 in FastSinc, and then every F-th sample after that. In bypass, every sample emits a result. The driver records the cycle of each such sample and enqueues the expected value with a due cycle one later. The monitor samples on the falling edge. It flags a result that arrives on any other cycle, arrives with a wrong value, arrives without an entry, or fails to arrive. Expected values come from a direct convolution with boxcar coefficients built in the bench, and the bench applies its own saturation.

// File: rtl/sinc_decim.sv
module sinc_decim #(
  parameter int OSR_W = 5,
  parameter int OUT_W = 16,
  parameter int ACC_W = 27,
  parameter int CNT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic                    in_valid,
  input  logic                    in_bit,
  input  logic [OSR_W-1:0]        osr_m1,
  input  logic [2:0]              order_sel,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);

  localparam int STG = 5;
  localparam logic signed [ACC_W-1:0] SMAX = ACC_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] SMIN = ~SMAX;
  localparam logic signed [OUT_W-1:0] OMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OMIN = {1'b1, {(OUT_W-1){1'b0}}};

  logic bypass, fast;
  logic [2:0] ord;
  logic [OSR_W:0] fosr, rem0, rem1, rem2, rem3;
  logic [CNT_W-1:0] settle, cnt, cnt_next;
  logic [OSR_W-1:0] phase, phase_next;
  logic take, decim, emit;

  assign bypass = (osr_m1 == '0);
  assign fast   = (order_sel == 3'd0);
  assign ord    = fast ? 3'd2 : (order_sel > 3'd5 ? 3'd5 : order_sel);
  assign fosr   = {1'b0, osr_m1} + 1'b1;

  assign settle = fast ? (CNT_W'(fosr) << 2) + CNT_W'(3)
                       : CNT_W'(fosr) * CNT_W'(ord) + CNT_W'(ord) + CNT_W'(1);

  // decimation phase aligned so that the settle sample is a decimation point
  assign rem0 = fast ? (OSR_W+1)'(3) : (OSR_W+1)'(ord) + 1'b1;
  assign rem1 = (rem0 >= fosr) ? rem0 - fosr : rem0;
  assign rem2 = (rem1 >= fosr) ? rem1 - fosr : rem1;
  assign rem3 = (rem2 >= fosr) ? rem2 - fosr : rem2;

  assign take       = en && in_valid;
  assign phase_next = (phase == osr_m1) ? '0 : phase + 1'b1;
  assign cnt_next   = (cnt == '1) ? cnt : cnt + 1'b1;
  assign decim      = take && !bypass && ({1'b0, phase_next} == rem3);
  assign emit       = decim && (cnt_next >= settle);

  logic signed [ACC_W-1:0] x;
  logic signed [ACC_W-1:0] integ [STG];
  logic signed [ACC_W-1:0] inx   [STG];
  logic signed [ACC_W-1:0] d1    [STG];
  logic signed [ACC_W-1:0] d2    [STG];
  logic signed [ACC_W-1:0] cmb   [STG+1];
  logic signed [ACC_W-1:0] res;
  logic signed [OUT_W-1:0] sat;

  assign x = in_bit ? {{(ACC_W-1){1'b0}}, 1'b1} : {ACC_W{1'b1}};

  always_comb begin
    inx[0] = integ[0] + x;
    for (int k = 1; k < STG; k++) inx[k] = integ[k] + inx[k-1];
    cmb[0] = inx[ord - 3'd1];
    for (int k = 1; k <= STG; k++) cmb[k] = cmb[k-1] - (fast ? d2[k-1] : d1[k-1]);
    res = cmb[ord];
  end

  assign sat = (res > SMAX) ? OMAX : (res < SMIN) ? OMIN : res[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      phase <= '0;
      out_valid <= 1'b0;
      out_data <= '0;
      for (int k = 0; k < STG; k++) begin
        integ[k] <= '0; d1[k] <= '0; d2[k] <= '0;
      end
    end else if (!en) begin
      cnt <= '0;
      phase <= '0;
      out_valid <= 1'b0;
      out_data <= '0;
      for (int k = 0; k < STG; k++) begin
        integ[k] <= '0; d1[k] <= '0; d2[k] <= '0;
      end
    end else begin
      out_valid <= take && (bypass || emit);
      if (take && bypass) out_data <= in_bit ? OUT_W'(1) : {OUT_W{1'b1}};
      else if (emit) out_data <= sat;
      if (take && !bypass) begin
        cnt <= cnt_next;
        phase <= phase_next;
        for (int k = 0; k < STG; k++) integ[k] <= inx[k];
      end
      if (decim) begin
        for (int k = 0; k < STG; k++) begin
          d1[k] <= cmb[k];
          d2[k] <= d1[k];
        end
      end
    end
  end

  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!out_valid && out_data == '0));

  assert_pulse_needs_sample_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(in_valid) && $past(en)));

  assert_no_early_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(bypass)) |-> ($past(cnt_next) >= $past(settle)));

  assert_bypass_unit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(bypass)) |-> (out_data == OUT_W'(1) || out_data == {OUT_W{1'b1}}));

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && phase == '0));

endmodule

// File: tb/test_sinc_decim.sv
module test_sinc_decim;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic [4:0] osr_m1 = 5'd0;
  logic [2:0] order_sel = 3'd1;
  logic out_valid;
  logic signed [15:0] out_data;

  sinc_decim i_sinc_decim (.clk(clk), .rst_n(rst_n), .en(en), .in_valid(in_valid),
    .in_bit(in_bit), .osr_m1(osr_m1), .order_sel(order_sel),
    .out_valid(out_valid), .out_data(out_data));

  always #2.5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  int hist[$];
  int exp_data[$];
  int exp_due[$];
  string exp_req[$];
  int nsamp = 0;
  int lfsr = 32'h1234ACE1;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model(int n_ord, int f, bit fst);
    int h[$];
    int len, reps, y;
    len = fst ? 2*f : f;
    reps = fst ? 2 : n_ord;
    h.push_back(1);
    for (int r = 0; r < reps; r++) begin
      int nh[$];
      for (int i = 0; i < h.size() + len - 1; i++) begin
        int s = 0;
        for (int j = 0; j < len; j++)
          if (i - j >= 0 && i - j < h.size()) s += h[i-j];
        nh.push_back(s);
      end
      h = nh;
    end
    y = 0;
    for (int k = 0; k < h.size(); k++)
      if (hist.size() - 1 - k >= 0) y += h[k] * hist[hist.size()-1-k];
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return y;
  endfunction

  task automatic feed(bit b, int gap, string req);
    int f, n, s;
    bit fst;
    f = int'(osr_m1) + 1;
    fst = (order_sel == 0);
    n = fst ? 2 : (order_sel > 5 ? 5 : int'(order_sel));
    s = fst ? 4*f + 3 : f*n + n + 1;
    @(negedge clk);
    in_valid = 1'b1;
    in_bit = b;
    hist.push_back(b ? 1 : -1);
    nsamp++;
    if (osr_m1 == 0) begin
      exp_data.push_back(b ? 1 : -1); exp_due.push_back(cyc + 1); exp_req.push_back(req);
    end else if (nsamp >= s && ((nsamp - s) % f) == 0) begin
      exp_data.push_back(model(n, f, fst)); exp_due.push_back(cyc + 1); exp_req.push_back(req);
    end
    repeat (gap) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  function automatic bit rnd();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >>> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return lfsr[3];
  endfunction

  task automatic restart(int m1, int sel);
    @(negedge clk);
    in_valid = 1'b0;
    en = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 16'sd0) begin
      failures++;
      $display("FAIL R1 disabled outputs: valid=%0b data=%0d expected 0/0", out_valid, out_data);
    end
    osr_m1 = 5'(m1);
    order_sel = 3'(sel);
    hist.delete();
    nsamp = 0;
    @(negedge clk);
    en = 1'b1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid === 1'b1) begin
        checks++;
        if (exp_data.size() == 0) begin
          failures++;
          $display("FAIL R10 unexpected result: actual=%0d expected none", out_data);
        end else begin
          if (exp_due[0] != cyc || out_data !== 16'(exp_data[0])) begin
            failures++;
            $display("FAIL %s result: actual=%0d at cycle %0d expected=%0d at cycle %0d",
                     exp_req[0], out_data, cyc, exp_data[0], exp_due[0]);
          end
          void'(exp_data.pop_front()); void'(exp_due.pop_front()); void'(exp_req.pop_front());
        end
      end else if (exp_due.size() != 0 && exp_due[0] <= cyc) begin
        checks++;
        failures++;
        $display("FAIL %s missing result: actual=none expected=%0d at cycle %0d",
                 exp_req[0], exp_data[0], exp_due[0]);
        void'(exp_data.pop_front()); void'(exp_due.pop_front()); void'(exp_req.pop_front());
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 16'sd0) begin
      failures++;
      $display("FAIL R1 reset state: valid=%0b data=%0d expected 0/0", out_valid, out_data);
    end
    rst_n = 1'b1;

    // R4 R3: Sinc3, F=4, constant ones -> first at sample 16, value 64
    restart(3, 3);
    for (int i = 0; i < 30; i++) feed(1'b1, 1, "R4");
    // R6 R3: Sinc1, F=2, random, back-to-back strobes
    restart(1, 1);
    for (int i = 0; i < 20; i++) feed(rnd(), 0, "R6");
    // R7: Sinc5, F=8, ones clamp to 32767
    restart(7, 5);
    for (int i = 0; i < 62; i++) feed(1'b1, 1, "R7");
    // R7: zeros reach -32768 exactly
    restart(7, 5);
    for (int i = 0; i < 62; i++) feed(1'b0, 0, "R7");
    // R5: FastSinc, F=4, random -> first at 19
    restart(3, 0);
    for (int i = 0; i < 40; i++) feed(rnd(), 1, "R5");
    // R5: FastSinc, F=2, random
    restart(1, 0);
    for (int i = 0; i < 25; i++) feed(rnd(), 0, "R5");
    // R2: order_sel 6 behaves as order 5, F=3
    restart(2, 6);
    for (int i = 0; i < 30; i++) feed(rnd(), 1, "R2");
    // R3: Sinc2, F=32, random
    restart(31, 2);
    for (int i = 0; i < 140; i++) feed(rnd(), 0, "R3");
    // R3: Sinc4, F=5, random with gaps
    restart(4, 4);
    for (int i = 0; i < 45; i++) feed(rnd(), 2, "R3");
    // R8: bypass
    restart(0, 3);
    for (int i = 0; i < 8; i++) feed(rnd(), i % 2, "R8");
    // R9: drop enable mid-stream, then restart settling
    restart(3, 2);
    for (int i = 0; i < 7; i++) feed(rnd(), 1, "R9");
    restart(3, 2);
    for (int i = 0; i < 25; i++) feed(rnd(), 1, "R9");

    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    checks++;
    if (exp_data.size() != 0) begin
      failures++;
      $display("FAIL R10 pending results: actual=%0d left expected 0", exp_data.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule